// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a virtual address onto a physical address through a small register-held table of segment descriptors. The upper bits of the virtual address pick a descriptor. The lower bits are an offset into that segment. Each descriptor holds a physical base, an inclusive offset limit and a protection code. A request carries the virtual address and the kind of access wanted. One clock later the block returns one of two results: the base plus the offset, or a fault with a cause code.

Software loads descriptors through a write port that replaces a whole descriptor in one cycle. After reset, every descriptor grants nothing. Every access therefore faults until the table has been loaded. A request that arrives in the same cycle as a write to its own descriptor is translated with the old contents. The new contents apply from the next request onward.

Top module: `seg_xlate_top`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low after a cycle with `req_valid` low.
- R2: Bits [18:16] of `req_va` select one of the 8 descriptors, and bits [15:0] form the offset. Two segments loaded with different bases give different physical addresses for the same offset.
- R3: A legal access returns `rsp_fault` = 2'b00 and `rsp_pa` = base + zero-extended offset, modulo 2^24 (the sum wraps).
- R4: An offset greater than the descriptor limit returns `rsp_fault` = 2'b01 and `rsp_pa` = 0. An offset equal to the limit is legal.
- R5: Protection codes are 2'b00 none, 2'b01 read, 2'b10 write and 2'b11 execute. Access kinds on `req_kind` use the same codes. The access is granted only when the kind equals the descriptor code and is not none. Otherwise the response is `rsp_fault` = 2'b10 and `rsp_pa` = 0.
- R6: When both the limit check and the protection check fail, `rsp_fault` is 2'b01.
- R7: After reset, every descriptor has protection none and the maximum limit. Any access then returns `rsp_fault` = 2'b10.
- R8: A descriptor write loads the base, limit and protection of entry `wr_seg`. A request in the same cycle to that entry is translated with the previous contents, and the next request sees the new ones.
- R9: A descriptor write leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 19 | Virtual address: segment number in [18:16], offset in [15:0] |
| req_kind | input | 2 | Access kind (01 read, 10 write, 11 execute) |
| wr_en | input | 1 | Descriptor write strobe |
| wr_seg | input | 3 | Descriptor index to write |
| wr_base | input | 24 | New physical base |
| wr_limit | input | 16 | New inclusive offset limit |
| wr_prot | input | 2 | New protection code |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 2 | 00 ok, 01 bound violation, 10 protection violation |
| rsp_pa | output | 24 | Physical address, zero on a fault |

## Verification
A corrupted descriptor register shows up on the first request that selects that entry, one cycle after the request. The symptom is a wrong physical address or a wrong fault code. A write decode that hits the wrong entry shows up when a neighbour segment is used, which the mixed random traffic does constantly. Read-during-write ordering errors appear only in the cycle right after a same-cycle write and request, so that case is driven both directly and by random collisions.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    PROT_NONE  = 2'b00,
    PROT_READ  = 2'b01,
    PROT_WRITE = 2'b10,
    PROT_EXEC  = 2'b11
  } prot_e;

  typedef enum logic [1:0] {
    FLT_OK    = 2'b00,
    FLT_BOUND = 2'b01,
    FLT_PROT  = 2'b10
  } fault_e;

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int NSEG   = 8,
  parameter int IDX_W  = 3,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_lim,
  input  prot_e             wr_prot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_lim,
  output prot_e             rd_prot
);

  logic [BASE_W-1:0] base_q [NSEG];
  logic [LIM_W-1:0]  lim_q  [NSEG];
  prot_e             prot_q [NSEG];
  logic [BASE_W-1:0] base_d [NSEG];
  logic [LIM_W-1:0]  lim_d  [NSEG];
  prot_e             prot_d [NSEG];
  logic [NSEG-1:0]   hit;

  // per-entry write decode
  for (genvar g = 0; g < NSEG; g++) begin : g_hit
    assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      base_d[i] = hit[i] ? wr_base : base_q[i];
      lim_d[i]  = hit[i] ? wr_lim  : lim_q[i];
      prot_d[i] = hit[i] ? wr_prot : prot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '1;
        prot_q[i] <= PROT_NONE;
      end
    end else begin
      for (int i = 0; i < NSEG; i++) begin
        if (hit[i]) begin
          base_q[i] <= base_d[i];
          lim_q[i]  <= lim_d[i];
          prot_q[i] <= prot_d[i];
        end
      end
    end
  end

  // read returns contents before any write in this cycle
  always_comb begin
    rd_base = '0;
    rd_lim  = '0;
    rd_prot = PROT_NONE;
    for (int i = 0; i < NSEG; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_base = base_q[i];
        rd_lim  = lim_q[i];
        rd_prot = prot_q[i];
      end
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int PA_W  = 24
) (
  input  logic [OFF_W-1:0] off,
  input  prot_e            kind,
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W-1:0] lim,
  input  prot_e            prot,
  output fault_e           fault,
  output logic [PA_W-1:0]  pa
);

  logic over;
  logic deny;
  logic [PA_W-1:0] sum;

  always_comb begin
    over  = off > lim;
    deny  = (prot == PROT_NONE) || (kind != prot);
    sum   = base + PA_W'(off);
    if (over)      fault = FLT_BOUND;
    else if (deny) fault = FLT_PROT;
    else           fault = FLT_OK;
    pa = (over || deny) ? '0 : sum;
  end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 8,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  localparam int IDX_W = $clog2(NSEG),
  localparam int VA_W  = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_kind,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_seg,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic [1:0]       wr_prot,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_pa
);

  logic [IDX_W-1:0] req_seg;
  logic [OFF_W-1:0] req_off;
  logic [PA_W-1:0]  ent_base;
  logic [OFF_W-1:0] ent_lim;
  prot_e            ent_prot;
  fault_e           chk_fault;
  logic [PA_W-1:0]  chk_pa;

  logic             valid_d;
  logic [1:0]       fault_d;
  logic [PA_W-1:0]  pa_d;

  assign req_seg = req_va[VA_W-1:OFF_W];
  assign req_off = req_va[OFF_W-1:0];

  seg_table #(
    .NSEG(NSEG), .IDX_W(IDX_W), .BASE_W(PA_W), .LIM_W(OFF_W)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_seg),
    .wr_base(wr_base),
    .wr_lim (wr_limit),
    .wr_prot(prot_e'(wr_prot)),
    .rd_idx (req_seg),
    .rd_base(ent_base),
    .rd_lim (ent_lim),
    .rd_prot(ent_prot)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .off  (req_off),
    .kind (prot_e'(req_kind)),
    .base (ent_base),
    .lim  (ent_lim),
    .prot (ent_prot),
    .fault(chk_fault),
    .pa   (chk_pa)
  );

  always_comb begin
    valid_d = req_valid;
    fault_d = req_valid ? chk_fault : rsp_fault;
    pa_d    = req_valid ? chk_pa    : rsp_pa;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 2'b00;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= valid_d;
      if (req_valid) begin
        rsp_fault <= fault_d;
        rsp_pa    <= pa_d;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int OFF_W = 16,
  parameter int PA_W  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [OFF_W-1:0] req_off,
  input logic [PA_W-1:0]  ent_base,
  input logic [OFF_W-1:0] ent_lim,
  input logic [1:0]       ent_prot,
  input logic             rsp_valid,
  input logic [1:0]       rsp_fault,
  input logic [PA_W-1:0]  rsp_pa
);

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((rsp_fault == 2'b01) == ($past(req_off) > $past(ent_lim))));

  a_r5_prot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_off <= ent_lim && req_kind != ent_prot) |=> rsp_fault == 2'b10);

  a_r3_sum: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_fault != 2'b00 ||
                   rsp_pa == $past(ent_base) + PA_W'($past(req_off))));

  a_r4_no_pa_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_pa == '0);

  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);

endmodule

bind seg_xlate_top seg_xlate_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_kind (req_kind),
  .req_off  (req_off),
  .ent_base (ent_base),
  .ent_lim  (ent_lim),
  .ent_prot (ent_prot),
  .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault),
  .rsp_pa   (rsp_pa)
);

// File: tb/seg_xlate_top_test.sv
`timescale 1ns/1ps
module seg_xlate_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [18:0] req_va;
  logic [1:0]  req_kind;
  logic        wr_en;
  logic [2:0]  wr_seg;
  logic [23:0] wr_base;
  logic [15:0] wr_limit;
  logic [1:0]  wr_prot;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [23:0] rsp_pa;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [23:0] m_base [8];
  logic [15:0] m_lim  [8];
  logic [1:0]  m_prot [8];

  always #2.5 clk = ~clk;

  seg_xlate_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_kind(req_kind), .wr_en(wr_en), .wr_seg(wr_seg), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_prot(wr_prot), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
  );

  function automatic logic [1:0] exp_fault(input logic [2:0] s,
                                           input logic [15:0] o,
                                           input logic [1:0] k);
    if (o > m_lim[s]) return 2'b01;
    if (m_prot[s] == 2'b00 || k != m_prot[s]) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [23:0] exp_pa(input logic [2:0] s,
                                         input logic [15:0] o,
                                         input logic [1:0] k);
    if (exp_fault(s, o, k) != 2'b00) return 24'h0;
    return m_base[s] + {8'h00, o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check result at the next negedge
  task automatic step(input bit rv, input logic [2:0] s, input logic [15:0] o,
                      input logic [1:0] k, input bit we, input logic [2:0] ws,
                      input logic [23:0] wb, input logic [15:0] wl,
                      input logic [1:0] wp, input string tag);
    logic [1:0]  ef;
    logic [23:0] ep;
    req_valid = rv; req_va = {s, o}; req_kind = k;
    wr_en = we; wr_seg = ws; wr_base = wb; wr_limit = wl; wr_prot = wp;
    ef = exp_fault(s, o, k);
    ep = exp_pa(s, o, k);
    if (we) begin
      m_base[ws] = wb; m_lim[ws] = wl; m_prot[ws] = wp;
    end
    @(negedge clk);
    check({tag, " R1 valid"}, {31'd0, rsp_valid}, {31'd0, rv});
    if (rv) begin
      check({tag, " fault"}, {30'd0, rsp_fault}, {30'd0, ef});
      check({tag, " pa"}, {8'd0, rsp_pa}, {8'd0, ep});
    end
  endtask

  task automatic load(input logic [2:0] ws, input logic [23:0] wb,
                      input logic [15:0] wl, input logic [1:0] wp);
    step(0, 0, 0, 0, 1, ws, wb, wl, wp, "R8 load");
  endtask

  task automatic req(input logic [2:0] s, input logic [15:0] o,
                     input logic [1:0] k, input string tag);
    step(1, s, o, k, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5E6A11));
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 24'h0; m_lim[i] = 16'hFFFF; m_prot[i] = 2'b00;
    end
    rst_n = 1'b0; req_valid = 0; req_va = 0; req_kind = 0;
    wr_en = 0; wr_seg = 0; wr_base = 0; wr_limit = 0; wr_prot = 0;
    repeat (3) @(negedge clk);
    check("R7 reset valid low", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: every entry denies after reset
    for (int s = 0; s < 8; s++) begin
      req(3'(s), 16'(s * 4099), 2'(1 + s % 3), "R7 reset deny");
      check("R7 code", {30'd0, rsp_fault}, 32'd2);
    end

    // load table
    load(0, 24'h010000, 16'h0FFF, 2'b01);
    load(1, 24'h200000, 16'h00FF, 2'b10);
    load(2, 24'h300000, 16'hFFFF, 2'b11);
    load(3, 24'hFFFFF0, 16'h0100, 2'b01);

    req(0, 16'h0123, 2'b01, "R3 legal read");
    req(1, 16'h0123, 2'b10, "R2 R4 other seg same off over limit");
    req(1, 16'h0023, 2'b10, "R2 other base");
    req(0, 16'h0FFF, 2'b01, "R4 off equals limit legal");
    req(0, 16'h1000, 2'b01, "R4 limit plus one");
    req(0, 16'h0010, 2'b10, "R5 write to read seg");
    req(2, 16'h0010, 2'b01, "R5 read to exec seg");
    req(2, 16'hFFFF, 2'b11, "R3 exec legal max off");
    req(0, 16'h0010, 2'b00, "R5 kind none");
    req(4, 16'h0000, 2'b01, "R5 prot none");
    req(1, 16'h0200, 2'b01, "R6 both fail");
    req(3, 16'h0020, 2'b01, "R3 wrap");
    check("R3 wrap value", {8'd0, rsp_pa}, 32'h000010);

    // R8: same-cycle write and request use old contents
    step(1, 0, 16'h0040, 2'b01, 1, 0, 24'h050000, 16'h00FF, 2'b10, "R8 old contents");
    req(0, 16'h0040, 2'b10, "R8 new contents");
    check("R8 new pa", {8'd0, rsp_pa}, 32'h050040);
    // R9: neighbour untouched
    load(5, 24'h777000, 16'h0001, 2'b11);
    req(4, 16'h0000, 2'b01, "R9 neighbour still none");
    req(2, 16'h0010, 2'b11, "R9 neighbour still exec");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [2:0]  s  = 3'($urandom);
      logic [15:0] o  = ($urandom % 4 == 0) ? m_lim[s] + 16'($urandom % 3) - 16'd1
                                            : 16'($urandom);
      bit          rv = ($urandom % 5) != 0;
      bit          we = ($urandom % 4) == 0;
      logic [15:0] wl = ($urandom % 2) ? 16'($urandom % 512) : 16'($urandom);
      step(rv, s, o, 2'($urandom), we, 3'($urandom), 24'($urandom), wl,
           2'($urandom), "R3 R4 R5 R8 R9 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule